// File: doc/BRIEF.md
# Override-Gated Management Register Bank

This block holds a small set of PHY management registers behind a simple parallel port. The port carries a register address, write data, a write strobe, a read strobe and registered read data. A vendor control register has three roles. It arms a one-shot override that unlocks protected bits elsewhere in the bank. It holds the PHY's management address, which is captured from strap pins at hardware reset. It also drives two static controls toward the transmit and receive paths: a descrambler lose-lock request and the NRZ/NRZI line-coding select.

Protected bits change only on the single write that directly follows an arming write. Every write consumes the arm, whatever register it targets. The arming write itself never counts as the armed write. A software-reset bit returns every field to its default except the captured PHY address. It also clears any pending arm.

Register map (5-bit address): 0 is the general control register, 16 is the vendor control register, and 17 is the auxiliary register. Every other address reads zero and ignores writes.

Top module: `mgmt_override_bank`

## Requirements
- R1: After hardware reset, register 0 reads 0x3000, register 17 reads 0x0000, and register 16 reads {bit15 arm=0, bits10:6 = strap_phy_addr, bit3 = 1, all other bits 0}.
- R2: A write to register 16 with bit 15 set arms the bank, and register 16 then reads bit 15 as 1. The next write to any address clears the arm.
- R3: A write to register 17 while the bank is not armed updates bits 15:2 and leaves the protected bits 1:0 unchanged.
- R4: A write to register 17 while the bank is armed updates all 16 bits. A further write without re-arming leaves bits 1:0 unchanged again.
- R5: The arming write is not itself an armed write. A write to register 16 with bit 15 set while already armed consumes the old arm and sets a new one.
- R6: Register 16 bit 5 is readable and writable, and the lose_lock output equals its value.
- R7: Register 16 bit 3 is readable and writable, and the nrzi_sel output equals its value (1 = NRZI, 0 = NRZ).
- R8: Register 16 bits 14:11, bit 4 and bits 2:0 always read 0, whatever was written. Bits 10:6 take the written PHY address.
- R9: A write to register 0 with bit 15 set is a software reset. It restores registers 0 and 17, register 16 bits 5 and 3, and the arm to their reset values. It keeps register 16 bits 10:6. Register 0 bit 15 always reads 0.
- R10: rdata shows the addressed register one clock after a cycle with rd_en high and holds otherwise. Unmapped addresses read 0. A write to an unmapped address changes no register but still consumes the arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| strap_phy_addr | input | 5 | PHY address straps captured during hardware reset |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 16 | Registered read data |
| lose_lock | output | 1 | Request to the descrambler to drop lock |
| nrzi_sel | output | 1 | Transmit coding select, 1 = NRZI |

## Verification
The auxiliary register is first written with all ones while the bank is disarmed, and that write must leave its protected bits alone. The same register is then written while armed, which must take the protected bits. A write right after the armed one separates a true one-shot arm from a sticky one. A double arm followed by a write, and an arm spent on an unmapped address, separate "any write consumes the arm" from "only a write to the target consumes it". Finally, a vendor-register write with every reserved bit set, followed by a software reset after the PHY address has been changed, separates the fields the reset restores from the field it must keep.

// File: rtl/mob_pkg.sv
package mob_pkg;

    typedef struct packed {
        logic [4:0] phy;
        logic       scr;
        logic       nrzi;
    } vend_t;

    localparam logic [14:0] CTRL_DEFAULT = 15'h3000;
    localparam logic        NRZI_DEFAULT = 1'b1;

endpackage

// File: rtl/mob_arm.sv
module mob_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic arm_req,
    output logic armed
);
    logic arm_d, arm_q;

    always_comb begin
        arm_d = arm_q;
        if (wr_en) arm_d = arm_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= arm_d;
    end

    assign armed = arm_q;

    // R2
    arm_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && wr_en && !arm_req) |=> !arm_q);

    // R5
    arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && arm_req) |=> arm_q);
endmodule

// File: rtl/mob_vendor.sv
module mob_vendor
    import mob_pkg::*;
#(
    parameter int PHY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PHY_W-1:0] strap,
    input  logic             wr,
    input  logic [PHY_W-1:0] w_phy,
    input  logic             w_scr,
    input  logic             w_nrzi,
    input  logic             sw_rst,
    output vend_t            q
);
    vend_t vend_d, vend_q;

    always_comb begin
        vend_d = vend_q;
        if (sw_rst) begin
            vend_d.scr  = 1'b0;
            vend_d.nrzi = NRZI_DEFAULT;
        end else if (wr) begin
            vend_d.phy  = w_phy;
            vend_d.scr  = w_scr;
            vend_d.nrzi = w_nrzi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vend_q.phy  <= strap;
            vend_q.scr  <= 1'b0;
            vend_q.nrzi <= NRZI_DEFAULT;
        end else begin
            vend_q <= vend_d;
        end
    end

    assign q = vend_q;

    // R9
    phy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> $stable(vend_q.phy));

    // R6
    scr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sw_rst) |=> (vend_q.scr == $past(w_scr)));
endmodule

// File: rtl/mob_aux.sv
module mob_aux #(
    parameter int DW     = 16,
    parameter int PROT_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          armed,
    input  logic          sw_rst,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    logic [DW-1:0] aux_d, aux_q;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i < PROT_W) begin : g_prot
            always_comb begin
                aux_d[i] = aux_q[i];
                if (sw_rst)          aux_d[i] = 1'b0;
                else if (wr && armed) aux_d[i] = wdata[i];
            end
        end else begin : g_open
            always_comb begin
                aux_d[i] = aux_q[i];
                if (sw_rst)  aux_d[i] = 1'b0;
                else if (wr) aux_d[i] = wdata[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) aux_q <= '0;
        else        aux_q <= aux_d;
    end

    assign q = aux_q;

    // R3
    prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !armed && !sw_rst) |=> $stable(aux_q[PROT_W-1:0]));

    // R4
    prot_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && armed && !sw_rst) |=> (aux_q == $past(wdata)));
endmodule

// File: rtl/mgmt_override_bank.sv
module mgmt_override_bank
    import mob_pkg::*;
#(
    parameter int          AW        = 5,
    parameter int          DW        = 16,
    parameter int          PHY_W     = 5,
    parameter int          PROT_W    = 2,
    parameter logic [AW-1:0] CTRL_ADDR = 5'd0,
    parameter logic [AW-1:0] VEND_ADDR = 5'd16,
    parameter logic [AW-1:0] AUX_ADDR  = 5'd17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PHY_W-1:0] strap_phy_addr,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [DW-1:0]    rdata,
    output logic             lose_lock,
    output logic             nrzi_sel
);
    localparam int TOP = DW - 1;

    typedef struct packed {
        logic [TOP-1:0] ctrl;
        logic [DW-1:0]  rd;
    } top_t;

    top_t top_d, top_q;

    logic          sw_rst, arm_req, armed;
    logic          wr_vend, wr_aux;
    vend_t         vend;
    logic [DW-1:0] aux;
    logic [DW-1:0] rd_mux;

    assign sw_rst  = wr_en && (addr == CTRL_ADDR) && wdata[TOP];
    assign arm_req = (addr == VEND_ADDR) && wdata[TOP];
    assign wr_vend = wr_en && (addr == VEND_ADDR);
    assign wr_aux  = wr_en && (addr == AUX_ADDR);

    mob_arm u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .arm_req (arm_req),
        .armed   (armed)
    );

    mob_vendor #(.PHY_W(PHY_W)) u_vendor (
        .clk    (clk),
        .rst_n  (rst_n),
        .strap  (strap_phy_addr),
        .wr     (wr_vend),
        .w_phy  (wdata[10:6]),
        .w_scr  (wdata[5]),
        .w_nrzi (wdata[3]),
        .sw_rst (sw_rst),
        .q      (vend)
    );

    mob_aux #(.DW(DW), .PROT_W(PROT_W)) u_aux (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_aux),
        .armed  (armed),
        .sw_rst (sw_rst),
        .wdata  (wdata),
        .q      (aux)
    );

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            CTRL_ADDR: rd_mux = {1'b0, top_q.ctrl};
            VEND_ADDR: rd_mux = {armed, 4'b0000, vend.phy, vend.scr,
                                 1'b0, vend.nrzi, 3'b000};
            AUX_ADDR:  rd_mux = aux;
            default:   rd_mux = '0;
        endcase
    end

    always_comb begin
        top_d = top_q;
        if (sw_rst)
            top_d.ctrl = CTRL_DEFAULT;
        else if (wr_en && (addr == CTRL_ADDR))
            top_d.ctrl = wdata[TOP-1:0];
        if (rd_en)
            top_d.rd = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q.ctrl <= CTRL_DEFAULT;
            top_q.rd   <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign rdata     = top_q.rd;
    assign lose_lock = vend.scr;
    assign nrzi_sel  = vend.nrzi;

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && (addr == VEND_ADDR)) |->
            (rdata[14:11] == 4'b0000 && rdata[4] == 1'b0 && rdata[2:0] == 3'b000));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R9
    swrst_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (top_q.ctrl == CTRL_DEFAULT && !armed && !lose_lock));
endmodule

// File: tb/mgmt_override_bank_bench.sv
module mgmt_override_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_phy_addr = 5'h0B;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rdata;
    logic        lose_lock, nrzi_sel;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgmt_override_bank u_mgmt_override_bank (
        .clk            (clk),
        .rst_n          (rst_n),
        .strap_phy_addr (strap_phy_addr),
        .addr           (addr),
        .wdata          (wdata),
        .wr_en          (wr_en),
        .rd_en          (rd_en),
        .rdata          (rdata),
        .lose_lock      (lose_lock),
        .nrzi_sel       (nrzi_sel)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: read strobe seen at an edge, rdata valid by the next falling edge
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 actual=%h expected=none", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        strap_phy_addr = 5'h1F;   // straps only matter during reset
        // R1 reset state
        rd(5'd0,  16'h3000, "R1 ctrl");
        rd(5'd17, 16'h0000, "R1 aux");
        rd(5'd16, 16'h02C8, "R1 vendor");
        check("R7 nrzi reset", {15'b0, nrzi_sel}, 16'h0001);
        check("R6 lose_lock reset", {15'b0, lose_lock}, 16'h0000);
        // R3 unarmed write keeps protected bits
        wr(5'd17, 16'hFFFF);
        rd(5'd17, 16'hFFFC, "R3 unarmed");
        // R2 arm visible
        wr(5'd16, 16'h82C8);
        rd(5'd16, 16'h82C8, "R2 armed flag");
        // R4 armed write applies, arm consumed
        wr(5'd17, 16'h0003);
        rd(5'd17, 16'h0003, "R4 armed write");
        rd(5'd16, 16'h02C8, "R2 arm cleared");
        wr(5'd17, 16'h0000);
        rd(5'd17, 16'h0003, "R4 second write ignored");
        // R5 double arm re-arms
        wr(5'd16, 16'h82C8);
        wr(5'd16, 16'h82C8);
        rd(5'd16, 16'h82C8, "R5 rearm");
        wr(5'd17, 16'h0001);
        rd(5'd17, 16'h0001, "R5 armed after rearm");
        // R10 arm spent on unmapped address
        wr(5'd16, 16'h82C8);
        wr(5'd5,  16'hFFFF);
        wr(5'd17, 16'h0002);
        rd(5'd17, 16'h0001, "R10 unmapped consumes arm");
        rd(5'd5,  16'h0000, "R10 unmapped reads zero");
        // R6 scrambler test bit
        wr(5'd16, 16'h02E8);
        rd(5'd16, 16'h02E8, "R6 scr readback");
        check("R6 lose_lock set", {15'b0, lose_lock}, 16'h0001);
        // R8 reserved bits, R7 NRZ select
        wr(5'd16, 16'h7C17);
        rd(5'd16, 16'h0400, "R8 reserved zero");
        check("R7 nrz select", {15'b0, nrzi_sel}, 16'h0000);
        check("R6 lose_lock clear", {15'b0, lose_lock}, 16'h0000);
        // R9 software reset
        wr(5'd0,  16'h0123);
        rd(5'd0,  16'h0123, "R9 ctrl write");
        wr(5'd17, 16'h1234);
        rd(5'd17, 16'h1235, "R3 open bits update");
        wr(5'd16, 16'h8420);
        wr(5'd0,  16'h8000);
        rd(5'd0,  16'h3000, "R9 ctrl default");
        rd(5'd17, 16'h0000, "R9 aux default");
        rd(5'd16, 16'h0408, "R9 phy kept");
        check("R9 nrzi default", {15'b0, nrzi_sel}, 16'h0001);
        check("R9 lose_lock default", {15'b0, lose_lock}, 16'h0000);
        repeat (3) @(negedge clk);
        check("R10 queue drained", 16'(exp_q.size()), 16'h0000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule